// File: doc/BRIEF.md
# Daisy-Chain PWM Driver Sequencer

This block feeds a chain of serially loaded 16-channel LED/PWM driver chips, each channel holding a 12-bit grayscale level. It keeps two copies of the frame. The live copy is the one being shifted out. The working copy is the one the host edits. The two copies trade places only while the outputs are blanked. The block drives the grayscale clock, the blanking strobe, the latch strobe, and a serial clock and data pair. The serial pair idles low and is sampled on the rising edge, which is SPI mode 0. It runs back-to-back grayscale cycles of `GS_STEPS` pulses each.

Host writes arrive on a valid/ready port. A write is accepted on a rising clock edge when `wr_valid` and `wr_ready` are both high. `wr_ready` falls for exactly one cycle: the first blanking cycle, when the buffers may trade places. The host must hold the channel and level stable until the write is accepted. Two transfer modes are available. In overlapped mode (`alt_mode` low), a fresh frame is shifted while the outputs run and is latched at the next blanking point. In stretched mode (`alt_mode` high), every blanking interval is held open until a whole frame has been shifted and latched.

Top module: `pwm_chain_seq`

## Requirements
- R1: A frame is 16·N_CHIPS·12 serial bits. The highest channel goes first and the lowest channel goes last, with each level MSB first. Each bit takes two system clocks. `sclk` idles low and rises only while `sdata` is stable, so the last bit shifted is bit 0 of channel 0.
- R2: Between the fall of `blank` and its next rise, `gs_clk` pulses exactly `GS_STEPS` times. `gs_clk` is low during the cycle before `blank` rises.
- R3: `xlat` is a pulse one clock wide and occurs only while `blank` is high.
- R4: In overlapped mode, a frame is shifted after a blanking point only if that blanking point swapped in new data, or if a forced refresh is pending. Such a frame is latched at the following blanking point. A blanking point with nothing new produces no `xlat`.
- R5: In stretched mode, every blanking interval shifts a whole frame and pulses `xlat` once before `blank` falls. `blank` therefore stays high for at least 2·frame-bits clocks.
- R6: An accepted write of an in-range channel sets that channel's level in the next latched frame. Every other channel keeps its current live level, because the live copy is copied into the working copy before the first edit.
- R7: The buffers trade places only in the first blanking cycle, and `wr_ready` is low in exactly that cycle. A write made mid-cycle produces no serial activity before the next `blank` rise.
- R8: After reset, `blank` is high, `gs_clk` and `xlat` are low, and an all-zero frame is shifted and latched before any grayscale cycle starts.
- R9: While `enable` is low, `blank` is high and `gs_clk` is low from the next clock on. Raising `enable` again forces one full frame to be shifted and latched.
- R10: A write whose channel index is at or above 16·N_CHIPS is accepted but ignored. It starts no shift and causes no latch, and the frame is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Global output enable |
| alt_mode | input | 1 | 1 = stretched blanking transfer, 0 = overlapped transfer |
| wr_valid | input | 1 | Host write request |
| wr_ready | output | 1 | Write accepted when high together with wr_valid |
| wr_chan | input | clog2(16·N_CHIPS)+1 | Channel index of the write |
| wr_level | input | 12 | Grayscale level of the write |
| gs_clk | output | 1 | Grayscale counting clock to the chain |
| blank | output | 1 | Output blanking strobe |
| xlat | output | 1 | Latch strobe for the shifted frame |
| sclk | output | 1 | Serial shift clock (mode 0) |
| sdata | output | 1 | Serial data |

## Verification
The hardest case to reach is a batch of host writes that straddles a blanking point. Part of the batch is swapped into one frame and the rest into the next, and only the later latched frame must match the full set of writes. Random batches with random channels and levels are issued with no regard to cycle phase, so some of them land across a swap. Each check waits three blanking points before comparing the frame it reconstructs from `sclk`/`sdata`. Directed steps cover the rest. One disables the block in the middle of a grayscale cycle. One writes just after a shift has finished, to show that nothing moves before the next blank. One writes out-of-range indices to show that no latch follows.

// File: rtl/pwmchain_pkg.sv
package pwmchain_pkg;
  localparam int LVL_W       = 12;
  localparam int CH_PER_CHIP = 16;

  typedef logic [LVL_W-1:0] level_t;

  typedef enum logic [3:0] {
    S_INIT_GO,
    S_INIT_WAIT,
    S_INIT_LAT,
    S_OFF,
    S_B0,
    S_B1,
    S_BSHIFT,
    S_BLAT,
    S_RUN,
    S_GAP
  } seq_state_t;
endpackage

// File: rtl/pwm_frame_store.sv
module pwm_frame_store
  import pwmchain_pkg::*;
#(
  parameter int NCH = 32,
  parameter int IW  = 5,
  parameter int CW  = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_fire,
  input  logic [CW-1:0] wr_chan,
  input  level_t        wr_level,
  input  logic          swap,
  input  logic [IW-1:0] rd_chan,
  output level_t        rd_level,
  output logic          dirty
);
  level_t bank0 [NCH];
  level_t bank1 [NCH];
  logic   live_sel;   // 0: bank0 is live, 1: bank1 is live
  logic   in_range;
  logic   write_ok;
  logic   copy_all;

  assign in_range = (wr_chan < CW'(NCH));
  assign write_ok = wr_fire && in_range;
  assign copy_all = write_ok && !dirty;

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bank0[i] <= '0;
      end else if (live_sel) begin
        if (write_ok && wr_chan == CW'(i)) bank0[i] <= wr_level;
        else if (copy_all)                 bank0[i] <= bank1[i];
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bank1[i] <= '0;
      end else if (!live_sel) begin
        if (write_ok && wr_chan == CW'(i)) bank1[i] <= wr_level;
        else if (copy_all)                 bank1[i] <= bank0[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_sel <= 1'b0;
      dirty    <= 1'b0;
    end else if (swap && dirty) begin
      live_sel <= ~live_sel;
      dirty    <= 1'b0;
    end else if (write_ok) begin
      dirty    <= 1'b1;
    end
  end

  assign rd_level = live_sel ? bank1[rd_chan] : bank0[rd_chan];

  a_r10_oor_stays_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !in_range && !dirty && !swap) |=> !dirty);
  a_r7_swap_clears_dirty: assert property (@(posedge clk) disable iff (!rst_n)
    (swap && dirty) |=> (!dirty && live_sel != $past(live_sel)));
endmodule

// File: rtl/pwm_shifter.sv
module pwm_shifter
  import pwmchain_pkg::*;
#(
  parameter int NCH = 32,
  parameter int IW  = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          zero,
  input  level_t        rd_level,
  output logic [IW-1:0] rd_chan,
  output logic          busy,
  output logic          sclk,
  output logic          sdata
);
  logic          phase_q;
  logic          ending_q;
  logic          zero_q;
  logic [IW-1:0] chan_q;
  logic [3:0]    bit_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      phase_q  <= 1'b0;
      ending_q <= 1'b0;
      zero_q   <= 1'b0;
      chan_q   <= '0;
      bit_q    <= '0;
      sclk     <= 1'b0;
      sdata    <= 1'b0;
    end else if (!busy) begin
      sclk <= 1'b0;
      if (start) begin
        busy     <= 1'b1;
        phase_q  <= 1'b0;
        ending_q <= 1'b0;
        zero_q   <= zero;
        chan_q   <= IW'(NCH - 1);
        bit_q    <= 4'(LVL_W - 1);
      end
    end else if (ending_q) begin
      sclk     <= 1'b0;
      busy     <= 1'b0;
      ending_q <= 1'b0;
    end else if (!phase_q) begin
      sdata   <= zero_q ? 1'b0 : rd_level[bit_q];
      sclk    <= 1'b0;
      phase_q <= 1'b1;
    end else begin
      sclk    <= 1'b1;
      phase_q <= 1'b0;
      if (bit_q == 4'd0) begin
        bit_q <= 4'(LVL_W - 1);
        if (chan_q == '0) ending_q <= 1'b1;
        else              chan_q   <= chan_q - 1'b1;
      end else begin
        bit_q <= bit_q - 1'b1;
      end
    end
  end

  assign rd_chan = chan_q;

  a_r1_sclk_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> busy);
  a_r1_data_stable_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $stable(sdata));
endmodule

// File: rtl/pwm_gs_seq.sv
module pwm_gs_seq
  import pwmchain_pkg::*;
#(
  parameter int GS_STEPS = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic alt_mode,
  input  logic dirty,
  input  logic shift_busy,
  output logic shift_start,
  output logic shift_zero,
  output logic swap,
  output logic wr_ready,
  output logic gs_clk,
  output logic blank,
  output logic xlat
);
  localparam int CNT_W = (GS_STEPS > 1) ? $clog2(GS_STEPS) : 1;

  seq_state_t state, nxt;
  logic [CNT_W-1:0] cnt;
  logic latch_pend, did_swap, force_q, mode_q;

  always_comb begin
    nxt         = state;
    shift_start = 1'b0;
    shift_zero  = 1'b0;
    case (state)
      S_INIT_GO:   begin shift_start = 1'b1; shift_zero = 1'b1; nxt = S_INIT_WAIT; end
      S_INIT_WAIT: if (!shift_busy) nxt = S_INIT_LAT;
      S_INIT_LAT:  nxt = S_OFF;
      S_OFF:       if (enable && !shift_busy) nxt = S_B0;
      S_B0:        nxt = S_B1;
      S_B1: begin
        if (!enable) nxt = S_OFF;
        else if (alt_mode) begin
          shift_start = 1'b1;
          nxt = S_BSHIFT;
        end else begin
          shift_start = did_swap || force_q;
          nxt = S_RUN;
        end
      end
      S_BSHIFT:    if (!shift_busy) nxt = S_BLAT;
      S_BLAT:      nxt = enable ? S_RUN : S_OFF;
      S_RUN: begin
        if (!enable) nxt = S_OFF;
        else if (gs_clk && cnt == CNT_W'(GS_STEPS - 1)) nxt = S_GAP;
      end
      S_GAP: begin
        if (!enable) nxt = S_OFF;
        else if (!shift_busy) nxt = S_B0;
      end
      default:     nxt = S_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_INIT_GO;
      gs_clk     <= 1'b0;
      cnt        <= '0;
      latch_pend <= 1'b0;
      did_swap   <= 1'b0;
      force_q    <= 1'b0;
      mode_q     <= 1'b0;
    end else begin
      state  <= nxt;
      gs_clk <= (state == S_RUN && nxt == S_RUN) ? ~gs_clk : 1'b0;
      if (state != S_RUN) cnt <= '0;
      else if (gs_clk)    cnt <= cnt + 1'b1;
      if (state == S_B0) did_swap <= dirty;
      if (state == S_OFF) force_q <= 1'b1;
      if (state == S_B1) begin
        latch_pend <= enable && !alt_mode && (did_swap || force_q);
        mode_q     <= alt_mode;
        if (enable) force_q <= 1'b0;
      end
    end
  end

  assign blank    = !(state == S_RUN || state == S_GAP);
  assign xlat     = (state == S_B1 && latch_pend) || state == S_BLAT || state == S_INIT_LAT;
  assign swap     = (state == S_B0);
  assign wr_ready = !swap;

  a_r3_xlat_in_blank: assert property (@(posedge clk) disable iff (!rst_n)
    xlat |-> blank);
  a_r3_xlat_single: assert property (@(posedge clk) disable iff (!rst_n)
    xlat |=> !xlat);
  a_r9_disable_blanks: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (blank && !gs_clk));
  a_r2_gap_before_blank: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(blank) && $past(enable)) |-> $past(!gs_clk));
  a_r5_latch_before_release: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(blank) && mode_q) |-> $past(xlat));
  a_r2_clock_only_unblanked: assert property (@(posedge clk) disable iff (!rst_n)
    gs_clk |-> !blank);
endmodule

// File: rtl/pwm_chain_seq.sv
module pwm_chain_seq
  import pwmchain_pkg::*;
#(
  parameter int N_CHIPS  = 2,
  parameter int GS_STEPS = 4096
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               enable,
  input  logic                               alt_mode,
  input  logic                               wr_valid,
  output logic                               wr_ready,
  input  logic [$clog2(16*N_CHIPS):0]        wr_chan,
  input  logic [11:0]                        wr_level,
  output logic                               gs_clk,
  output logic                               blank,
  output logic                               xlat,
  output logic                               sclk,
  output logic                               sdata
);
  localparam int NCH = CH_PER_CHIP * N_CHIPS;
  localparam int IW  = $clog2(NCH);
  localparam int CW  = IW + 1;

  logic          swap, dirty, shift_start, shift_zero, shift_busy;
  logic [IW-1:0] rd_chan;
  level_t        rd_level;

  pwm_frame_store #(.NCH(NCH), .IW(IW), .CW(CW)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_fire  (wr_valid && wr_ready),
    .wr_chan  (wr_chan),
    .wr_level (wr_level),
    .swap     (swap),
    .rd_chan  (rd_chan),
    .rd_level (rd_level),
    .dirty    (dirty)
  );

  pwm_shifter #(.NCH(NCH), .IW(IW)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (shift_start),
    .zero     (shift_zero),
    .rd_level (rd_level),
    .rd_chan  (rd_chan),
    .busy     (shift_busy),
    .sclk     (sclk),
    .sdata    (sdata)
  );

  pwm_gs_seq #(.GS_STEPS(GS_STEPS)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .alt_mode    (alt_mode),
    .dirty       (dirty),
    .shift_busy  (shift_busy),
    .shift_start (shift_start),
    .shift_zero  (shift_zero),
    .swap        (swap),
    .wr_ready    (wr_ready),
    .gs_clk      (gs_clk),
    .blank       (blank),
    .xlat        (xlat)
  );
endmodule

// File: tb/sim_pwm_chain_seq.sv
module sim_pwm_chain_seq;
  localparam int N_CHIPS  = 2;
  localparam int GS_STEPS = 512;
  localparam int NCH      = 16 * N_CHIPS;
  localparam int FB       = NCH * 12;
  localparam int CW       = $clog2(NCH) + 1;

  logic clk = 1'b0;
  logic rst_n, enable, alt_mode, wr_valid, wr_ready;
  logic [CW-1:0] wr_chan;
  logic [11:0] wr_level;
  logic gs_clk, blank, xlat, sclk, sdata;

  always #4 clk = ~clk;

  pwm_chain_seq #(.N_CHIPS(N_CHIPS), .GS_STEPS(GS_STEPS)) u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .alt_mode(alt_mode),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_chan(wr_chan), .wr_level(wr_level),
    .gs_clk(gs_clk), .blank(blank), .xlat(xlat), .sclk(sclk), .sdata(sdata)
  );

  int n_chk = 0, n_bad = 0;
  logic [11:0] model [NCH];
  logic [FB-1:0] shreg = '0, snap = '0;
  int bits_since = 0, bits_at_latch = 0, xlat_cnt = 0, sclk_cnt = 0;
  int gs_run = 0, gs_total = 0, last_gs = 0, blank_len = 0, last_blank_len = 0;
  int r3_viol = 0;
  logic prev_x = 1'b0;

  always @(posedge sclk) begin shreg = {shreg[FB-2:0], sdata}; bits_since++; sclk_cnt++; end
  always @(posedge xlat) begin snap = shreg; bits_at_latch = bits_since; bits_since = 0; xlat_cnt++; end
  always @(posedge gs_clk) begin gs_run++; gs_total++; end
  always @(posedge blank) begin last_gs = gs_run; gs_run = 0; end
  always @(negedge clk) begin
    if (rst_n) begin
      if (xlat && !blank) r3_viol++;
      if (xlat && prev_x) r3_viol++;
      prev_x = xlat;
      if (blank) blank_len++;
      else if (blank_len != 0) begin last_blank_len = blank_len; blank_len = 0; end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin n_bad++; $display("FAIL %s actual=%0d expected=%0d", tag, act, exp); end
  endtask

  task automatic cmp_frame(input string tag);
    int bad_c = -1;
    for (int c = 0; c < NCH; c++)
      if (bad_c < 0 && snap[c*12 +: 12] != model[c]) bad_c = c;
    if (bad_c >= 0) chk(1'b0, {tag, " frame channel"}, int'(snap[bad_c*12 +: 12]), int'(model[bad_c]));
    else chk(1'b1, tag, 0, 0);
    chk(bits_at_latch == FB, {tag, " R1 bits per frame"}, bits_at_latch, FB);
  endtask

  task automatic wr(input int ch, input int lv);
    @(negedge clk);
    wr_valid = 1'b1; wr_chan = CW'(ch); wr_level = 12'(lv);
    while (!wr_ready) @(negedge clk);
    if (ch < NCH) model[ch] = 12'(lv);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(posedge blank);
    @(negedge blank);
    repeat (2) @(negedge clk);
  endtask

  task automatic rand_batch(input int n);
    for (int k = 0; k < n; k++) begin
      wr(int'($urandom_range(NCH - 1)), int'($urandom_range(4095)));
      repeat ($urandom_range(300)) @(negedge clk);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int x0, g0, s0, seed;
    seed = int'($urandom(32'd4242));
    rst_n = 1'b0; enable = 1'b0; alt_mode = 1'b0; wr_valid = 1'b0; wr_chan = '0; wr_level = '0;
    for (int c = 0; c < NCH; c++) model[c] = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(blank && !xlat && !gs_clk, "R8 reset outputs", {blank, xlat, gs_clk}, 3'b100);
    while (xlat_cnt == 0) @(negedge clk);
    cmp_frame("R8 zero frame");
    repeat (100) @(negedge clk);
    chk(gs_total == 0 && blank, "R9 held while disabled", gs_total, 0);

    enable = 1'b1;
    settle();
    chk(last_gs == GS_STEPS, "R2 pulses per cycle", last_gs, GS_STEPS);

    rand_batch(16);
    settle();
    cmp_frame("R6 random batch");

    x0 = xlat_cnt;
    settle();
    chk(xlat_cnt == x0, "R4 no latch when idle", xlat_cnt, x0);

    x0 = xlat_cnt;
    wr(5, 12'h6B3);
    settle();
    chk(xlat_cnt == x0 + 1, "R4 one latch per update", xlat_cnt, x0 + 1);
    cmp_frame("R6 single write keeps others");

    x0 = xlat_cnt;
    wr(NCH, 12'hFFF);
    wr(NCH + 7, 12'h123);
    settle();
    chk(xlat_cnt == x0, "R10 out-of-range no latch", xlat_cnt, x0);
    cmp_frame("R10 frame unchanged");

    wr(NCH - 1, 12'hA5C); wr(0, 12'h3F1); wr(1, 12'hFFF); wr(NCH - 2, 12'h000);
    settle();
    cmp_frame("R1 edge channels");
    chk(snap[FB-1 -: 12] == 12'hA5C, "R1 top channel first", int'(snap[FB-1 -: 12]), 12'hA5C);

    @(posedge blank); @(negedge clk);
    chk(!wr_ready, "R7 ready low at swap", wr_ready, 0);
    @(negedge clk);
    chk(wr_ready, "R7 ready back after swap", wr_ready, 1);
    @(negedge blank);
    repeat (800) @(negedge clk);
    s0 = sclk_cnt;
    wr(9, 12'h9C4);
    @(posedge blank);
    chk(sclk_cnt == s0, "R7 no shift before blank", sclk_cnt, s0);
    settle();
    cmp_frame("R7 mid-cycle write");

    @(negedge blank);
    repeat (100) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    chk(blank && !gs_clk, "R9 disable blanks next clock", {blank, gs_clk}, 2'b10);
    g0 = gs_total;
    repeat (60) @(negedge clk);
    chk(gs_total == g0 && blank, "R9 no grayscale pulses off", gs_total, g0);
    x0 = xlat_cnt;
    enable = 1'b1;
    settle();
    chk(xlat_cnt > x0, "R9 forced refresh on enable", xlat_cnt, x0 + 1);
    cmp_frame("R9 refreshed frame");

    alt_mode = 1'b1;
    settle();
    x0 = xlat_cnt;
    repeat (3) @(posedge blank);
    @(negedge blank);
    repeat (2) @(negedge clk);
    chk(xlat_cnt == x0 + 3, "R5 latch every cycle", xlat_cnt, x0 + 3);
    chk(last_blank_len >= 2 * FB, "R5 stretched blank", last_blank_len, 2 * FB);
    chk(last_gs == GS_STEPS, "R2 pulses in stretched mode", last_gs, GS_STEPS);
    rand_batch(10);
    settle();
    cmp_frame("R5 stretched random batch");

    alt_mode = 1'b0;
    settle();
    x0 = xlat_cnt;
    settle();
    chk(xlat_cnt == x0, "R4 idle after mode change", xlat_cnt, x0);

    chk(r3_viol == 0, "R3 latch pulse shape", r3_viol, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule